// File: doc/BRIEF.md
# Windowed Key-Service Watchdog

This block watches that software keeps running on schedule. Once it is switched on, an 8-bit counter starts from zero and advances by one on every clock. Software must refresh it with a two-byte key written to the service register. Both bytes must be correct and must arrive close together in time. The refresh must also complete while the counter lies inside a window set by a lower and an upper compare value. A refresh that is too early or malformed, or a counter that runs past the upper value, raises a sticky failure output. An interrupt request follows that output whenever interrupts are enabled.

An external monitor pin can force the same failure output. Its active level is selectable. The control bits that enable the counter, the pin and the polarity can be written once after reset, and so can both compare values. Any attempt to change them later is refused with a one-cycle bus error. Software reaches the block through a byte-wide register port with a 2-bit address.

Top module: `kwin_watchdog`

## Requirements
- R1: After reset the four registers read as follows: control at offset 0 reads 0x00, service at offset 1 reads 0x00, window-low at offset 2 reads 0x00 and window-high at offset 3 reads 0xFF. The fail, irq and bus-error outputs are low. Read data is valid in the cycle after the read strobe is sampled.
- R2: The control register has these bits: bit 0 turns the watchdog on, bit 1 selects the pin's active level (0 means low, 1 means high), bit 2 enables the pin and bit 3 enables the interrupt. Bits 7:4 read as zero. The first write to control sets bits 2:0. A later write that would change bits 2:0 leaves them unchanged and raises bus_err for one cycle after the write. Bit 3 can be rewritten at any time without an error.
- R3: Each compare register accepts only its first write after reset. Any later write leaves the value unchanged and raises bus_err for one cycle.
- R4: The service register always reads 0x00.
- R5: While the watchdog is off, service writes, counter time and the pin have no effect, and fail stays low. If the first control write leaves bit 0 clear, the watchdog cannot be turned on until reset.
- R6: The counter is zero in the cycle after the enabling write and then advances by one per cycle, saturating at 0xFF. fail rises on the edge where the count already exceeds window-high, which is H+2 cycles after the enabling write edge for a window-high of H. A window-high of 0xFF never expires.
- R7: A legal refresh is 0xB4 followed by 0x2C, with the second write sampled no more than SVC_WIN (default 15) cycles after the first. If the count at the second write is at least window-low and no more than window-high, the count restarts from zero.
- R8: A legal key pair completed while the count is below window-low raises fail.
- R9: An illegal sequence raises fail. This covers a wrong first byte, a wrong second byte, and a second byte that comes more than SVC_WIN cycles after the first.
- R10: When the pin is enabled and at its active level, fail rises on the next clock edge. When the pin is disabled, its level is ignored.
- R11: Once fail is raised, it stays high until reset.
- R12: irq_out is high while interrupt-enable and fail are both set. Writing interrupt-enable to 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on each rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after a refused write |
| mon_in | input | 1 | External monitor pin (already synchronous) |
| fail_out | output | 1 | Sticky watchdog failure, active high |
| irq_out | output | 1 | Interrupt request |

## Verification
Every register-port result is due one cycle after the edge that samples the strobe: bus_rdata, bus_err and a raised fail from a service or pin event. The bench drives strobes for exactly one cycle starting at a falling edge and compares results at the next falling edge. Counter-driven results are timed from the enabling write edge: expiry shows H+2 edges later, and a refresh sampled after d idle cycles and a gap g sees a count of d+g. The bench checks fail one falling edge before and one after each predicted change, so an off-by-one in the counter or in the compare shows up at the ports.

// File: rtl/kwin_pkg.sv
// Shared definitions for the keyed windowed watchdog.
// Assumes a byte-wide register port with four offsets.
package kwin_pkg;
    localparam int CTRL_W = 4;

    // Register offsets; decoded by the register file.
    typedef enum logic [1:0] {
        OFS_CTRL = 2'd0,
        OFS_SERV = 2'd1,
        OFS_WLO  = 2'd2,
        OFS_WHI  = 2'd3
    } reg_ofs_e;

    // Control bits, bit 3 down to bit 0.
    typedef struct packed {
        logic irq_en;
        logic pin_en;
        logic pin_hi;
        logic run;
    } ctrl_t;
endpackage

// File: rtl/kwin_regfile.sv
// Register file: write-once control and window registers, bus error
// on refused writes, registered read data, and the service-write strobe.
// Assumes at most one of wr/rd per cycle. Bit 3 of control stays writable.
module kwin_regfile
    import kwin_pkg::*;
#(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] WHI_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    addr,
    input  logic          wr,
    input  logic          rd,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          bus_err,
    output ctrl_t         ctrl,
    output logic [DW-1:0] win_lo,
    output logic [DW-1:0] win_hi,
    output logic          serv_wr
);
    localparam int PAD_W = DW - CTRL_W;

    logic ctrl_lock, lo_lock, hi_lock;
    reg_ofs_e ofs;

    assign ofs     = reg_ofs_e'(addr);
    assign serv_wr = wr && (ofs == OFS_SERV);

    // Accept writes, enforce write-once fields, flag refused writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl      <= '0;
            ctrl_lock <= 1'b0;
            lo_lock   <= 1'b0;
            hi_lock   <= 1'b0;
            win_lo    <= '0;
            win_hi    <= WHI_RST;
            bus_err   <= 1'b0;
        end else begin
            bus_err <= 1'b0;
            if (wr) begin
                case (ofs)
                    OFS_CTRL: begin
                        ctrl.irq_en <= wdata[3];
                        if (!ctrl_lock) begin
                            ctrl.run    <= wdata[0];
                            ctrl.pin_hi <= wdata[1];
                            ctrl.pin_en <= wdata[2];
                            ctrl_lock   <= 1'b1;
                        end else if (wdata[2:0] != ctrl[2:0]) begin
                            bus_err <= 1'b1;
                        end
                    end
                    OFS_WLO: begin
                        if (!lo_lock) begin
                            win_lo  <= wdata;
                            lo_lock <= 1'b1;
                        end else begin
                            bus_err <= 1'b1;
                        end
                    end
                    OFS_WHI: begin
                        if (!hi_lock) begin
                            win_hi  <= wdata;
                            hi_lock <= 1'b1;
                        end else begin
                            bus_err <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Return the addressed register one cycle after the read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            case (ofs)
                OFS_CTRL: rdata <= {{PAD_W{1'b0}}, ctrl};
                OFS_WLO:  rdata <= win_lo;
                OFS_WHI:  rdata <= win_hi;
                default:  rdata <= '0;
            endcase
        end else begin
            rdata <= '0;
        end
    end

    // R3
    wlo_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_lock |=> $stable(win_lo));
    // R3
    whi_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_lock |=> $stable(win_hi));
    // R2
    ctrl_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_lock |=> $stable(ctrl[2:0]));
endmodule

// File: rtl/kwin_keyseq.sv
// Key-sequence decoder: tracks the first key byte and the time since it.
// It reports a legal pair (svc_ok) or a broken one (svc_bad) in the
// same cycle as the completing service write. It is idle while inactive.
module kwin_keyseq #(
    parameter int            DW      = 8,
    parameter int            SVC_WIN = 15,
    parameter logic [DW-1:0] KEY_A   = 8'hB4,
    parameter logic [DW-1:0] KEY_B   = 8'h2C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          serv_wr,
    input  logic [DW-1:0] wdata,
    output logic          svc_ok,
    output logic          svc_bad
);
    localparam int            TW   = $clog2(SVC_WIN + 2);
    localparam logic [TW-1:0] LATE = TW'(SVC_WIN + 1);
    localparam logic [TW-1:0] LIM  = TW'(SVC_WIN);

    logic          armed;
    logic [TW-1:0] elapsed;

    assign svc_ok  = active && serv_wr && armed && (wdata == KEY_B) && (elapsed <= LIM);
    assign svc_bad = active && serv_wr && !svc_ok && (armed || (wdata != KEY_A));

    // Arm on the first key and count cycles since it, saturating past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            armed   <= 1'b0;
            elapsed <= '0;
        end else if (serv_wr) begin
            if (!armed && (wdata == KEY_A)) begin
                armed   <= 1'b1;
                elapsed <= TW'(1);
            end else begin
                armed   <= 1'b0;
                elapsed <= '0;
            end
        end else if (armed && (elapsed != LATE)) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // R7
    seq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_ok |=> !armed);
endmodule

// File: rtl/kwin_core.sv
// Counter and failure latch. It counts once per cycle while running and
// saturates at all-ones. It restarts on an in-window refresh and latches
// fail on expiry, an early or broken refresh, or an active monitor pin.
// Assumes mon_in is already synchronous to clk.
module kwin_core #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          pin_en,
    input  logic          pin_hi,
    input  logic          mon_in,
    input  logic [DW-1:0] win_lo,
    input  logic [DW-1:0] win_hi,
    input  logic          svc_ok,
    input  logic          svc_bad,
    output logic          fail
);
    logic [DW-1:0] cnt;
    logic          pin_act, early, expired;

    assign pin_act = pin_en && (mon_in == pin_hi);
    assign early   = svc_ok && (cnt < win_lo);
    assign expired = cnt > win_hi;

    // Advance the count, restart it on an in-window refresh.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (svc_ok && !early) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Latch the failure until reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            fail <= 1'b0;
        end else if (svc_bad || early || expired || pin_act) begin
            fail <= 1'b1;
        end
    end

    // R6
    expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt > win_hi) |=> fail);
    // R6
    saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == '1 && !svc_ok) |=> cnt == '1);
    // R8
    early_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && svc_ok && cnt < win_lo) |=> fail);
    // R9
    ok_bad_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(svc_ok && svc_bad));
    // R11
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> fail);
endmodule

// File: rtl/kwin_watchdog.sv
// Top of the keyed windowed watchdog: register file, key decoder and
// counter core, plus the interrupt gate.
// Assumes single-clock use with a synchronous active-low reset.
module kwin_watchdog
    import kwin_pkg::*;
#(
    parameter int          DW      = 8,
    parameter int          SVC_WIN = 15,
    parameter logic [7:0]  KEY_A   = 8'hB4,
    parameter logic [7:0]  KEY_B   = 8'h2C
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_err,
    input  logic          mon_in,
    output logic          fail_out,
    output logic          irq_out
);
    ctrl_t         ctrl;
    logic [DW-1:0] win_lo, win_hi;
    logic          serv_wr, svc_ok, svc_bad;

    kwin_regfile #(.DW(DW), .WHI_RST({DW{1'b1}})) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .rdata(bus_rdata), .bus_err(bus_err), .ctrl(ctrl),
        .win_lo(win_lo), .win_hi(win_hi), .serv_wr(serv_wr)
    );

    kwin_keyseq #(.DW(DW), .SVC_WIN(SVC_WIN), .KEY_A(DW'(KEY_A)), .KEY_B(DW'(KEY_B))) u_keys (
        .clk(clk), .rst_n(rst_n), .active(ctrl.run), .serv_wr(serv_wr),
        .wdata(bus_wdata), .svc_ok(svc_ok), .svc_bad(svc_bad)
    );

    kwin_core #(.DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .pin_en(ctrl.pin_en),
        .pin_hi(ctrl.pin_hi), .mon_in(mon_in), .win_lo(win_lo), .win_hi(win_hi),
        .svc_ok(svc_ok), .svc_bad(svc_bad), .fail(fail_out)
    );

    // Interrupt request follows the failure while enabled.
    assign irq_out = ctrl.irq_en && fail_out;

    // R12
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fail_out) && ctrl.irq_en) |-> irq_out);
endmodule

// File: tb/kwin_watchdog_bench.sv
module kwin_watchdog_bench;
    import kwin_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_err;
    logic       mon_in = 1'b1;
    logic       fail_out;
    logic       irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    kwin_watchdog u_kwin_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .mon_in(mon_in), .fail_out(fail_out), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [7:0] lo;
        logic [7:0] hi;
        logic [7:0] dly;
        logic [7:0] gap;
        logic [7:0] k1;
        logic [7:0] k2;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 12;
    // window-low, window-high, idle cycles, key gap, key1, key2, expected fail
    localparam vec_t VEC [NV] = '{
        '{8'd0,  8'd200, 8'd5,  8'd1,  8'hB4, 8'h2C, 8'd0},  // R7 plain refresh
        '{8'd20, 8'd200, 8'd5,  8'd1,  8'hB4, 8'h2C, 8'd1},  // R8 early
        '{8'd20, 8'd200, 8'd30, 8'd1,  8'hB4, 8'h2C, 8'd0},  // R7 inside window
        '{8'd20, 8'd200, 8'd18, 8'd1,  8'hB4, 8'h2C, 8'd1},  // R8 count 19
        '{8'd20, 8'd200, 8'd19, 8'd1,  8'hB4, 8'h2C, 8'd0},  // R7 count 20
        '{8'd0,  8'd200, 8'd5,  8'd1,  8'hB5, 8'h2C, 8'd1},  // R9 bad first
        '{8'd0,  8'd200, 8'd5,  8'd1,  8'hB4, 8'h2D, 8'd1},  // R9 bad second
        '{8'd0,  8'd200, 8'd5,  8'd15, 8'hB4, 8'h2C, 8'd0},  // R7 gap at limit
        '{8'd0,  8'd200, 8'd5,  8'd16, 8'hB4, 8'h2C, 8'd1},  // R9 gap too long
        '{8'd0,  8'd200, 8'd5,  8'd1,  8'h2C, 8'hB4, 8'd1},  // R9 swapped keys
        '{8'd0,  8'd20,  8'd19, 8'd1,  8'hB4, 8'h2C, 8'd0},  // R7 count equals high
        '{8'd0,  8'd20,  8'd20, 8'd1,  8'hB4, 8'h2C, 8'd1}   // R6 count past high
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;

        // Reset state (R1, R4)
        do_reset();
        chk("R1 fail after reset", {7'd0, fail_out}, 8'd0);
        chk("R1 irq after reset", {7'd0, irq_out}, 8'd0);
        chk("R1 bus_err after reset", {7'd0, bus_err}, 8'd0);
        rd(OFS_CTRL, d); chk("R1 control reset", d, 8'h00);
        rd(OFS_SERV, d); chk("R4 service reads zero", d, 8'h00);
        rd(OFS_WLO, d);  chk("R1 window-low reset", d, 8'h00);
        rd(OFS_WHI, d);  chk("R1 window-high reset", d, 8'hFF);

        // Vector table: refresh timing and key legality (R6..R9)
        for (int i = 0; i < NV; i++) begin
            do_reset();
            wr(OFS_WLO, VEC[i].lo);
            wr(OFS_WHI, VEC[i].hi);
            wr(OFS_CTRL, 8'h01);
            repeat (int'(VEC[i].dly)) @(negedge clk);
            wr(OFS_SERV, VEC[i].k1);
            repeat (int'(VEC[i].gap) - 1) @(negedge clk);
            wr(OFS_SERV, VEC[i].k2);
            chk($sformatf("R7/R8/R9 vector %0d fail", i), {7'd0, fail_out}, VEC[i].exp);
        end

        // Compare registers write-once (R3)
        do_reset();
        wr(OFS_WLO, 8'h10); chk("R3 first low write no error", {7'd0, bus_err}, 8'd0);
        wr(OFS_WLO, 8'h20); chk("R3 second low write error", {7'd0, bus_err}, 8'd1);
        rd(OFS_WLO, d);     chk("R3 low unchanged", d, 8'h10);
        wr(OFS_WHI, 8'h40); chk("R3 first high write no error", {7'd0, bus_err}, 8'd0);
        wr(OFS_WHI, 8'h50); chk("R3 second high write error", {7'd0, bus_err}, 8'd1);
        rd(OFS_WHI, d);     chk("R3 high unchanged", d, 8'h40);

        // Control write-once, irq bit free, reserved bits, watchdog off (R2, R5)
        wr(OFS_CTRL, 8'h0A); chk("R2 first control write", {7'd0, bus_err}, 8'd0);
        rd(OFS_CTRL, d);     chk("R2 control readback", d, 8'h0A);
        wr(OFS_CTRL, 8'h02); chk("R2 irq bit change no error", {7'd0, bus_err}, 8'd0);
        rd(OFS_CTRL, d);     chk("R2 irq bit cleared", d, 8'h02);
        wr(OFS_CTRL, 8'h03); chk("R2 locked bit change error", {7'd0, bus_err}, 8'd1);
        rd(OFS_CTRL, d);     chk("R5 run stays off", d, 8'h02);
        wr(OFS_CTRL, 8'hF2); chk("R2 reserved bits no error", {7'd0, bus_err}, 8'd0);
        rd(OFS_CTRL, d);     chk("R2 reserved bits read zero", d, 8'h02);
        wr(OFS_SERV, 8'h00); chk("R5 bad key ignored when off", {7'd0, fail_out}, 8'd0);
        wr(OFS_SERV, 8'hB4);
        rd(OFS_SERV, d);     chk("R4 service reads zero after write", d, 8'h00);
        repeat (300) @(negedge clk);
        chk("R5 no expiry when off", {7'd0, fail_out}, 8'd0);

        // Expiry timing at window-high 10 (R6), sticky (R11), irq (R12)
        do_reset();
        wr(OFS_WHI, 8'd10);
        wr(OFS_CTRL, 8'h01);
        repeat (11) @(negedge clk);
        chk("R6 no fail at H+1", {7'd0, fail_out}, 8'd0);
        @(negedge clk);
        chk("R6 fail at H+2", {7'd0, fail_out}, 8'd1);
        chk("R12 irq off while disabled", {7'd0, irq_out}, 8'd0);
        wr(OFS_CTRL, 8'h09);
        chk("R12 irq on when enabled", {7'd0, irq_out}, 8'd1);
        chk("R2 irq enable no error", {7'd0, bus_err}, 8'd0);
        wr(OFS_CTRL, 8'h01);
        chk("R12 irq cleared by write", {7'd0, irq_out}, 8'd0);
        repeat (5) @(negedge clk);
        chk("R11 fail sticky", {7'd0, fail_out}, 8'd1);

        // Refresh restarts the count (R7)
        do_reset();
        wr(OFS_WHI, 8'd30);
        wr(OFS_CTRL, 8'h01);
        repeat (19) @(negedge clk);
        wr(OFS_SERV, 8'hB4);
        wr(OFS_SERV, 8'h2C);
        repeat (31) @(negedge clk);
        chk("R7 restarted count not expired", {7'd0, fail_out}, 8'd0);
        @(negedge clk);
        chk("R7 restarted count expires at H+2", {7'd0, fail_out}, 8'd1);

        // Monitor pin, active low (R10)
        mon_in = 1'b1;
        do_reset();
        wr(OFS_CTRL, 8'h05);
        repeat (3) @(negedge clk);
        chk("R10 pin idle high no fail", {7'd0, fail_out}, 8'd0);
        mon_in = 1'b0;
        @(negedge clk);
        chk("R10 pin low asserts", {7'd0, fail_out}, 8'd1);

        // Monitor pin, active high (R10)
        mon_in = 1'b0;
        do_reset();
        wr(OFS_CTRL, 8'h07);
        repeat (3) @(negedge clk);
        chk("R10 pin idle low no fail", {7'd0, fail_out}, 8'd0);
        mon_in = 1'b1;
        @(negedge clk);
        chk("R10 pin high asserts", {7'd0, fail_out}, 8'd1);

        // Monitor pin disabled (R10)
        mon_in = 1'b0;
        do_reset();
        wr(OFS_CTRL, 8'h01);
        repeat (5) @(negedge clk);
        chk("R10 pin ignored when disabled", {7'd0, fail_out}, 8'd0);

        // Saturation with window-high 0xFF never expires (R6)
        repeat (400) @(negedge clk);
        chk("R6 saturated no expiry", {7'd0, fail_out}, 8'd0);
        wr(OFS_SERV, 8'hB4);
        wr(OFS_SERV, 8'h2C);
        chk("R7 refresh at saturated count", {7'd0, fail_out}, 8'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule